// File: doc/BRIEF.md
# Opcode-Selected Arithmetic Unit

This block is a purely combinational arithmetic unit. It takes two operand words and a three-bit function code and returns one result word. The lowest code bit decides whether the second operand is the input word or the constant one. The two upper code bits pick the operator. With this split, a single datapath covers add, increment, subtract, decrement and multiply.

The unit has no clock and no state. The result follows any change on the operand or code inputs. All arithmetic wraps modulo 2^WIDTH, and the block has no carry, borrow or overflow output. Any code whose upper two bits are both set gives a zero word. Every code therefore has a defined output, and none can infer a latch.

A parameter chooses between two adder structures. One is a single shared adder that subtracts by inverting its operand. The other uses separate add and subtract operators. Both give the same values at the ports.

Top module: `op_arith_unit`

## Requirements
- R1: Operands and result are WIDTH bits wide (default 32). Every result is the low WIDTH bits of the exact value, and any carry out of the top bit is discarded.
- R2: Code bit 0 selects the second operand. A value of 0 passes opb, and a value of 1 passes the constant 1.
- R3: When code bits [2:1] are 00, the result is the sum. Code 000 gives opa+opb and code 001 gives opa+1.
- R4: When code bits [2:1] are 01, the result is the difference modulo 2^WIDTH. Code 010 gives opa-opb and code 011 gives opa-1.
- R5: When code bits [2:1] are 10, the result is the low WIDTH bits of opa*opb. Codes 100 and 101 give the same value, so code bit 0 has no effect.
- R6: When code bits [2:1] are 11 (codes 110 and 111), the result is all zeros.
- R7: The block is combinational. The result settles from any change of opa, opb or func without a clock, and it is never unknown while the inputs are known.
- R8: Both adder structures (SHARE_ADDSUB = 1 and 0) give identical results for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, used when code bit 0 is 0 |
| func | input | 3 | Function code: bit 0 picks the operand, bits [2:1] pick the operator |
| res | output | WIDTH | Result, low WIDTH bits |

## Verification
The checker runs whenever any input changes. It confirms that the operand selector delivers either opb or the constant one, as code bit 0 directs. It also checks that the result equals the sum, the difference, the truncated product or zero, according to the upper code bits, and that the result holds no unknown bits while the inputs are known.

Only the bench scenarios can show the behaviour at specific values. These include wraparound at the all-ones and sign-bit operands, decrement of zero, and the fact that code bit 0 has no effect under multiply. The bench also shows that the shared-adder variant and the split-operator variant agree, because it builds one of each and sweeps both.

// File: rtl/op_arith_pkg.sv
package op_arith_pkg;

   // Operator encoding carried by function-code bits [2:1]
   typedef enum logic [1:0] {
      OPR_ADD  = 2'b00,
      OPR_SUB  = 2'b01,
      OPR_MUL  = 2'b10,
      OPR_NONE = 2'b11
   } opr_e;

   localparam int FUNC_W = 3;

endpackage

// File: rtl/op_arith_opnd_sel.sv
module op_arith_opnd_sel #(
   parameter int WIDTH = 32
) (
   input  logic             use_one,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] opnd
);
   localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

   always_comb begin
      if (use_one) opnd = ONE_W;
      else         opnd = opb;
   end
endmodule

// File: rtl/op_arith_core.sv
module op_arith_core #(
   parameter int WIDTH        = 32,
   parameter bit SHARE_ADDSUB = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opnd,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] dif_o,
   output logic [WIDTH-1:0] prd_o
);
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0] prd_full;

   generate
      if (SHARE_ADDSUB) begin : g_shared
         // One adder: subtraction via inverted operand plus carry-in
         logic [WIDTH-1:0] opnd_x;
         logic [WIDTH-1:0] acc;
         always_comb begin
            opnd_x = do_sub ? ~opnd : opnd;
            acc    = opa + opnd_x + WIDTH'(do_sub);
         end
         assign sum_o = acc;
         assign dif_o = acc;
      end else begin : g_split
         logic unused_sub;
         assign unused_sub = do_sub;
         assign sum_o = opa + opnd;
         assign dif_o = opa - opnd;
      end
   endgenerate

   always_comb prd_full = {{WIDTH{1'b0}}, opa} * {{WIDTH{1'b0}}, opnd};
   assign prd_o = prd_full[WIDTH-1:0];

   logic unused_hi;
   assign unused_hi = |prd_full[PW-1:WIDTH];
endmodule

// File: rtl/op_arith_unit.sv
module op_arith_unit
   import op_arith_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit SHARE_ADDSUB = 1'b1
) (
   input  logic [WIDTH-1:0]  opa,
   input  logic [WIDTH-1:0]  opb,
   input  logic [FUNC_W-1:0] func,
   output logic [WIDTH-1:0]  res
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("op_arith_unit: WIDTH must be at least 2");
      end
   endgenerate

   opr_e             opr;
   logic [WIDTH-1:0] sel_opnd;
   logic [WIDTH-1:0] sum_w, dif_w, prd_w;
   logic [WIDTH-1:0] mul_opb;

   assign opr = opr_e'(func[2:1]);

   op_arith_opnd_sel #(.WIDTH(WIDTH)) u_sel (
      .use_one (func[0]),
      .opb     (opb),
      .opnd    (sel_opnd)
   );

   // Multiply always uses opb: code bit 0 is ignored on that path
   assign mul_opb = (opr == OPR_MUL) ? opb : sel_opnd;

   op_arith_core #(.WIDTH(WIDTH), .SHARE_ADDSUB(SHARE_ADDSUB)) u_core (
      .opa    (opa),
      .opnd   (mul_opb),
      .do_sub (opr == OPR_SUB),
      .sum_o  (sum_w),
      .dif_o  (dif_w),
      .prd_o  (prd_w)
   );

   always_comb begin
      unique case (opr)
         OPR_ADD: res = sum_w;
         OPR_SUB: res = dif_w;
         OPR_MUL: res = prd_w;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/op_arith_unit_chk.sv
module op_arith_unit_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [2:0]       func,
   input logic [WIDTH-1:0] opnd,
   input logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] exp_p;
   always_comb exp_p = opa * opb;

   always_comb begin
      if (!$isunknown({opa, opb, func})) begin
         // R2
         opnd_sel_chk: assert (opnd == (func[0] ? WIDTH'(1) : opb));
         // R3
         if (func[2:1] == 2'b00) add_path_chk: assert (res == WIDTH'(opa + opnd));
         // R4
         if (func[2:1] == 2'b01) sub_path_chk: assert (res == WIDTH'(opa - opnd));
         // R5
         if (func[2:1] == 2'b10) mul_path_chk: assert (res == exp_p);
         // R6
         if (func[2:1] == 2'b11) unused_zero_chk: assert (res == '0);
         // R7
         res_known_chk: assert (!$isunknown(res));
      end
   end
endmodule

bind op_arith_unit op_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .opa  (opa),
   .opb  (opb),
   .func (func),
   .opnd (sel_opnd),
   .res  (res)
);

// File: tb/op_arith_unit_test.sv
module op_arith_unit_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [2:0]   f;
   logic [W-1:0] r_sh, r_sp;
   int           errs = 0, checks = 0, cycles = 0;
   logic         done = 1'b0;

   always #5 clk = ~clk;

   op_arith_unit #(.WIDTH(W), .SHARE_ADDSUB(1'b1)) uut (
      .opa(a), .opb(b), .func(f), .res(r_sh));
   op_arith_unit #(.WIDTH(W), .SHARE_ADDSUB(1'b0)) uut_split (
      .opa(a), .opb(b), .func(f), .res(r_sp));

   function automatic logic [W-1:0] model(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic [2:0] c);
      logic [W-1:0] s;
      logic [2*W-1:0] p;
      s = c[0] ? 1 : y;
      p = {32'd0, x} * {32'd0, y};
      case (c[2:1])
         2'b00:   return x + s;
         2'b01:   return x - s;
         2'b10:   return p[W-1:0];
         default: return '0;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] c);
      case (c)
         3'b000, 3'b001: return "R3";
         3'b010, 3'b011: return "R4";
         3'b100, 3'b101: return "R5";
         default:        return "R6";
      endcase
   endfunction

   task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s a=%h b=%h f=%b act=%h exp=%h", rq, a, b, f, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
      logic [W-1:0] e;
      @(negedge clk);
      a = x; b = y; f = c;
      #1;
      e = model(x, y, c);
      chk(tag(c), r_sh, e);
      // R8: split variant must match the shared-adder variant
      chk("R8", r_sp, e);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] edges [4];
      edges[0] = 32'h0; edges[1] = 32'h1;
      edges[2] = 32'hFFFF_FFFF; edges[3] = 32'h8000_0000;
      a = '0; b = '0; f = 3'b000;
      #2;
      // R7: idle inputs give a known zero result
      chk("R7", r_sh, '0);

      // R7: output follows an input change with no clock edge
      #1 a = 32'd5; b = 32'd7; f = 3'b000;
      #1 chk("R7", r_sh, 32'd12);
      #1 f = 3'b011;
      #1 chk("R7", r_sh, 32'd4);

      // R1: carry out of the top bit is dropped
      apply(32'hFFFF_FFFF, 32'h1, 3'b000);
      chk("R1", r_sh, 32'h0);
      // R2: f[0]=1 ignores opb for add
      apply(32'd10, 32'd999, 3'b001);
      chk("R2", r_sh, 32'd11);
      // R4: decrement of zero wraps
      apply(32'h0, 32'h1234, 3'b011);
      chk("R4", r_sh, 32'hFFFF_FFFF);
      // R5: code bit 0 has no effect on multiply
      apply(32'h0001_0003, 32'h0002_0005, 3'b101);
      chk("R5", r_sh, 32'h000B_000F);
      // R6: unused codes give zero
      apply(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b111);
      chk("R6", r_sh, 32'h0);

      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               apply(edges[i], edges[j], 3'(c));

      for (int c = 0; c < 8; c++)
         for (int k = 0; k < 40; k++)
            apply($urandom, $urandom, 3'(c));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule